// File: doc/BRIEF.md
# Dual-Channel Double-Buffered Converter Front End

This block sits between a parallel processor-style write port and a two-channel 8-bit converter core. Each channel has a staging register and a live register. A write stores the bus value in the staging register of the channel picked by the select line. The live registers drive the converter codes. They move only on a load strobe, which updates both channels together, on a write while the load strobe is held low, or on clear, which forces them to zero.

All strobes are asynchronous to the system clock. Each one passes through a two-flop synchroniser, and its edges are detected in the clock domain. The bus and the select line are delayed by the same number of stages, so they stay aligned with the strobes. A power-down input only raises a status flag. Register contents survive power-down, and writes are still taken while it is asserted.

Top module: `dual_dac_front`

## Requirements
- R1: After a synchronous reset, both output codes are 0x00 and `pd_o` is 0.
- R2: When a write ends (`cs_n` or `wr_n` returns high after both were low), the bus value goes into the staging register of one channel: `sel_b`=0 selects channel A and `sel_b`=1 selects channel B.
- R3: Toggling `wr_n` while `cs_n` stays high writes nothing. Both staging registers keep their contents.
- R4: A write while `load_n` is high leaves both output codes unchanged.
- R5: A falling edge on `load_n` copies both staging registers to their output codes in the same clock cycle.
- R6: While `load_n` is held low, the end of a write updates only the addressed channel's output code with the new bus value. The other channel's code stays the same.
- R7: While `clr_n` is low, both output codes are zero. Clear leaves the staging registers untouched, so a later load restores their contents.
- R8: `pd_o` is 1 while `pdn_n` is low. Output codes hold during power-down, and writes made during power-down are kept.
- R9: When clear and a load edge arrive in the same cycle, clear wins and both codes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_i | input | 8 | Parallel data bus |
| sel_b | input | 1 | Channel select: 0 = A, 1 = B |
| cs_n | input | 1 | Chip select, active low |
| wr_n | input | 1 | Write strobe, active low |
| load_n | input | 1 | Load strobe, active low |
| clr_n | input | 1 | Clear, active low |
| pdn_n | input | 1 | Power-down request, active low |
| code_a_o | output | 8 | Channel A output code |
| code_b_o | output | 8 | Channel B output code |
| pd_o | output | 1 | Power-down status |

## Verification
Two events can land in the same cycle: a load edge and a clear. Both can rewrite the live registers. The bench drives `load_n` and `clr_n` low on the same clock edge, so both pass through identical synchronisers and are detected together. The check is that both codes read zero. After both strobes are released, a further load must bring back the staged values, which shows that clear did not touch the staging registers.

// File: rtl/ddac_pkg.sv
package ddac_pkg;
  localparam int NUM_CH   = 2;
  localparam int NUM_STRB = 5;
  // bit positions of the strobe bundle fed to the synchroniser
  localparam int S_CS  = 0;
  localparam int S_WR  = 1;
  localparam int S_LD  = 2;
  localparam int S_CLR = 3;
  localparam int S_PD  = 4;
  typedef enum logic {CH_A = 1'b0, CH_B = 1'b1} chan_e;
endpackage

// File: rtl/ddac_sync.sv
module ddac_sync #(
  parameter int          W      = 1,
  parameter int          STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= d_i;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) stg[s] <= RST_VAL;
        else     stg[s] <= stg[s-1];
      end
    end
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/ddac_chan.sv
module ddac_chan #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          upd_en,
  input  logic          ld_all,
  input  logic          clr,
  output logic [DW-1:0] code_o
);
  logic [DW-1:0] in_q;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      in_q  <= '0;
      out_q <= '0;
    end else begin
      if (wr_en) in_q <= wr_data;
      if (clr)         out_q <= '0;
      else if (upd_en) out_q <= wr_data;
      else if (ld_all) out_q <= in_q;
    end
  end

  assign code_o = out_q;

  // R3: staging register moves only on a write
  a_r3_stage_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(in_q));
  // R4: no load, update or clear leaves the live code alone
  a_r4_live_hold: assert property (@(posedge clk) disable iff (rst)
    (!ld_all && !upd_en && !clr) |=> $stable(code_o));
  // R5: load copies the staged value
  a_r5_load_copy: assert property (@(posedge clk) disable iff (rst)
    (ld_all && !upd_en && !clr) |=> code_o == $past(in_q));
  // R6: transparent update takes the new bus value
  a_r6_transparent: assert property (@(posedge clk) disable iff (rst)
    (upd_en && !clr) |=> code_o == $past(wr_data));
  // R7 / R9: clear forces zero whatever else happens
  a_r7_clear_zero: assert property (@(posedge clk) disable iff (rst)
    clr |=> code_o == '0);
endmodule

// File: rtl/dual_dac_front.sv
module dual_dac_front
  import ddac_pkg::*;
#(
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [DW-1:0] bus_i,
  input  logic          sel_b,
  input  logic          cs_n,
  input  logic          wr_n,
  input  logic          load_n,
  input  logic          clr_n,
  input  logic          pdn_n,
  output logic [DW-1:0] code_a_o,
  output logic [DW-1:0] code_b_o,
  output logic          pd_o
);
  localparam int PW = DW + 1;

  logic [NUM_STRB-1:0] strb_raw, strb_s;
  logic [PW-1:0]       pay_raw, pay_s;

  assign strb_raw[S_CS]  = cs_n;
  assign strb_raw[S_WR]  = wr_n;
  assign strb_raw[S_LD]  = load_n;
  assign strb_raw[S_CLR] = clr_n;
  assign strb_raw[S_PD]  = pdn_n;
  assign pay_raw         = {sel_b, bus_i};

  ddac_sync #(.W(NUM_STRB), .STAGES(STAGES), .RST_VAL({NUM_STRB{1'b1}})) u_strb_sync (
    .clk(clk), .rst(rst), .d_i(strb_raw), .q_o(strb_s));

  ddac_sync #(.W(PW), .STAGES(STAGES), .RST_VAL('0)) u_pay_sync (
    .clk(clk), .rst(rst), .d_i(pay_raw), .q_o(pay_s));

  logic          act, prv_act, prv_ld;
  logic          wend, ld_fall, ld_low, clr_act;
  logic [DW-1:0] held_data;
  chan_e         held_sel;

  assign act     = !strb_s[S_CS] && !strb_s[S_WR];
  assign wend    = prv_act && !act;
  assign ld_fall = prv_ld && !strb_s[S_LD];
  assign ld_low  = !strb_s[S_LD];
  assign clr_act = !strb_s[S_CLR];

  always_ff @(posedge clk) begin
    if (rst) begin
      prv_act   <= 1'b0;
      prv_ld    <= 1'b1;
      held_data <= '0;
      held_sel  <= CH_A;
      pd_o      <= 1'b0;
    end else begin
      prv_act <= act;
      prv_ld  <= strb_s[S_LD];
      pd_o    <= !strb_s[S_PD];
      if (act) begin
        held_data <= pay_s[DW-1:0];
        held_sel  <= chan_e'(pay_s[DW]);
      end
    end
  end

  logic [NUM_CH-1:0] wr_en, upd_en;
  logic [DW-1:0]     codes [NUM_CH];

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    assign wr_en[i]  = wend && (held_sel == chan_e'(i));
    assign upd_en[i] = wr_en[i] && ld_low;
    ddac_chan #(.DW(DW)) u_chan (
      .clk(clk), .rst(rst),
      .wr_en(wr_en[i]), .wr_data(held_data),
      .upd_en(upd_en[i]), .ld_all(ld_fall), .clr(clr_act),
      .code_o(codes[i]));
  end

  assign code_a_o = codes[0];
  assign code_b_o = codes[1];

  // R2: a write touches at most one channel
  a_r2_one_channel: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_en));
  // R8: power-down request raises the flag
  a_r8_pd_flag: assert property (@(posedge clk) disable iff (rst)
    !strb_s[S_PD] |=> pd_o);
endmodule

// File: tb/tb_dual_dac_front.sv
module tb_dual_dac_front;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [7:0] bus_i = '0;
  logic       sel_b = 1'b0, cs_n = 1'b1, wr_n = 1'b1;
  logic       load_n = 1'b1, clr_n = 1'b1, pdn_n = 1'b1;
  logic [7:0] code_a_o, code_b_o;
  logic       pd_o;
  int n_chk = 0, n_bad = 0;

  always #4 clk = ~clk;

  dual_dac_front dut (
    .clk(clk), .rst(rst), .bus_i(bus_i), .sel_b(sel_b), .cs_n(cs_n),
    .wr_n(wr_n), .load_n(load_n), .clr_n(clr_n), .pdn_n(pdn_n),
    .code_a_o(code_a_o), .code_b_o(code_b_o), .pd_o(pd_o));

  task automatic chk(input string req, input logic [7:0] got, input logic [7:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic settle();
    repeat (6) @(negedge clk);
  endtask

  task automatic wr(input logic ch, input logic [7:0] d, input logic use_cs);
    @(negedge clk); sel_b = ch; bus_i = d; cs_n = !use_cs;
    @(negedge clk); wr_n = 1'b0;
    repeat (3) @(negedge clk); wr_n = 1'b1;
    repeat (3) @(negedge clk); cs_n = 1'b1; bus_i = 8'h00;
    settle();
  endtask

  task automatic pulse_load();
    @(negedge clk); load_n = 1'b0;
    repeat (3) @(negedge clk); load_n = 1'b1;
    settle();
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk); rst = 1'b0; settle();
    chk("R1 code A", code_a_o, 8'h00);
    chk("R1 code B", code_b_o, 8'h00);
    chk("R1 pd", {7'b0, pd_o}, 8'h00);
  endtask

  task automatic t_stage_then_load();
    wr(1'b0, 8'h5A, 1'b1);
    wr(1'b1, 8'hC3, 1'b1);
    chk("R4 A held", code_a_o, 8'h00);
    chk("R4 B held", code_b_o, 8'h00);
    pulse_load();
    chk("R5/R2 A", code_a_o, 8'h5A);
    chk("R5/R2 B", code_b_o, 8'hC3);
  endtask

  task automatic t_no_cs();
    wr(1'b0, 8'h11, 1'b0);
    pulse_load();
    chk("R3 A unchanged", code_a_o, 8'h5A);
    chk("R3 B unchanged", code_b_o, 8'hC3);
  endtask

  task automatic t_transparent();
    @(negedge clk); load_n = 1'b0; settle();
    wr(1'b1, 8'h7E, 1'b1);
    chk("R6 B updated", code_b_o, 8'h7E);
    chk("R6 A kept", code_a_o, 8'h5A);
    wr(1'b0, 8'hFF, 1'b1);
    chk("R6 A updated", code_a_o, 8'hFF);
    chk("R6 B kept", code_b_o, 8'h7E);
    @(negedge clk); load_n = 1'b1; settle();
  endtask

  task automatic t_clear();
    @(negedge clk); clr_n = 1'b0; settle();
    chk("R7 A zero", code_a_o, 8'h00);
    chk("R7 B zero", code_b_o, 8'h00);
    @(negedge clk); clr_n = 1'b1; settle();
    pulse_load();
    chk("R7 A restored", code_a_o, 8'hFF);
    chk("R7 B restored", code_b_o, 8'h7E);
  endtask

  task automatic t_clear_vs_load();
    @(negedge clk); clr_n = 1'b0; load_n = 1'b0; settle();
    chk("R9 A zero", code_a_o, 8'h00);
    chk("R9 B zero", code_b_o, 8'h00);
    @(negedge clk); clr_n = 1'b1; load_n = 1'b1; settle();
    pulse_load();
    chk("R9 A restored", code_a_o, 8'hFF);
    chk("R9 B restored", code_b_o, 8'h7E);
  endtask

  task automatic t_power_down();
    @(negedge clk); pdn_n = 1'b0; settle();
    chk("R8 pd set", {7'b0, pd_o}, 8'h01);
    chk("R8 A kept", code_a_o, 8'hFF);
    wr(1'b0, 8'h33, 1'b1);
    pulse_load();
    chk("R8 write in pd", code_a_o, 8'h33);
    chk("R8 B kept", code_b_o, 8'h7E);
    @(negedge clk); pdn_n = 1'b1; settle();
    chk("R8 pd clear", {7'b0, pd_o}, 8'h00);
  endtask

  initial begin
    t_reset();
    t_stage_then_load();
    t_no_cs();
    t_transparent();
    t_clear();
    t_clear_vs_load();
    t_power_down();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule